// File: doc/BRIEF.md
# Serial EEPROM Page-Write and Block-Read Sequencer

This block drives a byte-level two-wire bus engine so that whole blocks of data move to or from a serial EEPROM. Software or a neighbouring controller gives it a request: a 7-bit device address, a start offset inside the memory, a byte count and a read/write choice. For a write, the bytes come from a stream that the block consumes one at a time. The block splits the transfer into bursts that never cross an 8-byte page. Each burst is framed by START and STOP, and after each burst the block waits a programmable write-cycle time so that the memory can commit the page. For a read, the block first writes the offset, then issues a repeated START and clocks the requested bytes back. It marks the final byte so that the engine answers it with a not-acknowledge.

The engine is told what to do through a one-command-at-a-time interface. The block raises a command strobe, and the engine answers each command with a single completion pulse and a success bit. If the completion fails (a missing acknowledge or an incomplete byte), the block closes the bus with STOP and reports an error. If the engine reports lost arbitration when a request arrives, the block clears that flag and fails the request at once. Each request ends with a one-cycle done pulse that carries the number of data bytes moved and an error bit.

The memory offset is sent as one or two bytes, chosen by a parameter. A two-byte offset goes most significant byte first. The write-cycle wait is counted in system clock cycles.

Top module: `ee_page_seq`

## Requirements
- R1: A write burst issues, in order, START (cmd code 0), a WRITE (cmd code 3) of the byte {device address, 0}, then the offset byte(s), then data bytes taken from wr_data with one wr_take pulse per data byte.
- R2: With the default two-byte offset, the offset is sent as two WRITE commands, bits 15:8 first and then bits 7:0. The value sent is the offset of the first byte of that burst.
- R3: A write burst ends with STOP (cmd code 2) after the byte whose offset has its three low bits all ones, or after the last requested byte. Each later burst starts with a fresh START and the new offset.
- R4: When the start offset is not a multiple of 8, the first burst carries only the bytes up to the next multiple of 8.
- R5: After a write burst's STOP completes, no command is issued for WAIT_CYC cycles. The next START, or the done pulse after the last burst, appears exactly WAIT_CYC+1 cycles after the STOP completion is presented.
- R6: A read issues START, WRITE {device address, 0}, the offset byte(s), RSTART (cmd code 1), WRITE {device address, 1}, then one READ (cmd code 4) per requested byte with cmd_last high only on the final READ, then STOP. No wait follows.
- R7: Each successfully completed READ produces one rd_valid pulse carrying the byte returned by the engine, in request order.
- R8: If arb_lost is high when a request is accepted, arb_clr pulses, done pulses with done_err high and done_cnt 0 on the next cycle, and no command is issued.
- R9: A completion with eng_ok low on any command other than STOP is followed on the next cycle by a STOP command, and then by done with done_err high. done_cnt equals the number of data bytes completed successfully.
- R10: After reset, done, cmd_valid and busy are low. A request with byte count 0 finishes with done, count 0 and no error, and issues no command. busy is low whenever done pulses.
- R11: The block never issues a new command while a previous one is still awaiting its completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer (accepted while busy is low) |
| req_read | input | 1 | 1 = block read, 0 = page write |
| req_dev | input | 7 | Device address |
| req_ofs | input | 8*OFS_BYTES | Start offset in the memory |
| req_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Head of the write data stream |
| wr_take | output | 1 | Current wr_data consumed |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_cnt | output | LEN_W | Data bytes moved by the finished transfer |
| done_err | output | 1 | Transfer ended in error |
| arb_lost | input | 1 | Arbitration-lost flag from the engine |
| arb_clr | output | 1 | Pulse that clears the arbitration-lost flag |
| cmd_valid | output | 1 | Command strobe to the engine |
| cmd | output | 3 | Command code: 0 START, 1 RSTART, 2 STOP, 3 WRITE, 4 READ |
| cmd_data | output | 8 | Byte for a WRITE command |
| cmd_last | output | 1 | READ is the final one (answer with not-acknowledge) |
| eng_done | input | 1 | Completion pulse for the outstanding command |
| eng_ok | input | 1 | Completion succeeded (acknowledge received) |
| eng_rdata | input | 8 | Byte returned by a READ |

## Verification
The assertions assume that the engine raises eng_done only for a command that is still outstanding. They also assume eng_done is a single-cycle pulse that never comes in the same cycle as the command strobe, and that a request arrives only while busy is low. The bench's responder latches each strobe and answers two cycles later with one pulse. Requests are issued only after the previous done has been seen. The bench also clears its arbitration-lost flag only when arb_clr pulses. Failures are injected by command index, and the sequences that follow them are checked in full.

// File: rtl/ee_seq_pkg.sv
package ee_seq_pkg;
  typedef enum logic [2:0] {
    CMD_START  = 3'd0,
    CMD_RSTART = 3'd1,
    CMD_STOP   = 3'd2,
    CMD_WRITE  = 3'd3,
    CMD_READ   = 3'd4
  } eng_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DEV, ST_OFS, ST_DATA,
    ST_STOP, ST_WAIT, ST_RSTART, ST_RDEV, ST_READ
  } seq_state_e;
endpackage

// File: rtl/ee_seq_wait.sv
module ee_seq_wait #(
  parameter int WAIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fin
);
  localparam int WW = $clog2(WAIT_CYC + 1);
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fin = run && (cnt_q == WW'(WAIT_CYC - 1));
endmodule

// File: rtl/ee_seq_track.sv
module ee_seq_track #(
  parameter int OFS_W = 16,
  parameter int LEN_W = 8,
  parameter int PAGE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] ld_ofs,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             adv,
  output logic [OFS_W-1:0] cur_ofs,
  output logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] moved,
  output logic             last,
  output logic             page_end
);
  localparam int PB = $clog2(PAGE);
  logic [OFS_W-1:0] ofs_d;
  logic [LEN_W-1:0] rem_d, mov_d;

  always_comb begin
    ofs_d = cur_ofs;
    rem_d = remain;
    mov_d = moved;
    if (load) begin
      ofs_d = ld_ofs;
      rem_d = ld_len;
      mov_d = '0;
    end else if (adv) begin
      ofs_d = cur_ofs + 1'b1;
      rem_d = remain - 1'b1;
      mov_d = moved + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ofs <= '0;
      remain  <= '0;
      moved   <= '0;
    end else begin
      cur_ofs <= ofs_d;
      remain  <= rem_d;
      moved   <= mov_d;
    end
  end

  assign last     = (remain == LEN_W'(1));
  assign page_end = &cur_ofs[PB-1:0];
endmodule

// File: rtl/ee_page_seq.sv
module ee_page_seq
  import ee_seq_pkg::*;
#(
  parameter int OFS_BYTES = 2,
  parameter int LEN_W     = 8,
  parameter int PAGE      = 8,
  parameter int WAIT_CYC  = 330000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_read,
  input  logic [6:0]             req_dev,
  input  logic [8*OFS_BYTES-1:0] req_ofs,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [7:0]             wr_data,
  output logic                   wr_take,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  output logic                   busy,
  output logic                   done,
  output logic [LEN_W-1:0]       done_cnt,
  output logic                   done_err,
  input  logic                   arb_lost,
  output logic                   arb_clr,
  output logic                   cmd_valid,
  output logic [2:0]             cmd,
  output logic [7:0]             cmd_data,
  output logic                   cmd_last,
  input  logic                   eng_done,
  input  logic                   eng_ok,
  input  logic [7:0]             eng_rdata
);
  localparam int OFS_W = 8 * OFS_BYTES;

  seq_state_e       state, state_d;
  logic             pend, pend_d, abort, abort_d, rd_mode, rd_d;
  logic [0:0]       idx, idx_d;
  logic [6:0]       dev, dev_d;
  logic             done_d, err_d, rdv_d, clr_d, load, adv;
  logic [LEN_W-1:0] cnt_d;
  logic [7:0]       rdat_d, ofs_byte;
  logic [OFS_W-1:0] cur_ofs;
  logic [LEN_W-1:0] remain, moved;
  logic             last, page_end, wait_fin, issue, fin;
  eng_cmd_e         cmd_e;

  ee_seq_track #(.OFS_W(OFS_W), .LEN_W(LEN_W), .PAGE(PAGE)) u_track (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_ofs(req_ofs), .ld_len(req_len),
    .adv(adv), .cur_ofs(cur_ofs), .remain(remain), .moved(moved),
    .last(last), .page_end(page_end));

  ee_seq_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT), .fin(wait_fin));

  generate
    if (OFS_BYTES == 1) begin : g_ofs1
      assign ofs_byte = cur_ofs[7:0];
    end else begin : g_ofs2
      assign ofs_byte = idx[0] ? cur_ofs[15:8] : cur_ofs[7:0];
    end
  endgenerate

  assign busy  = (state != ST_IDLE);
  assign issue = busy && (state != ST_WAIT) && !pend;
  assign fin   = pend && eng_done;

  // command decode per state
  always_comb begin
    cmd_e    = CMD_STOP;
    cmd_data = 8'h00;
    cmd_last = 1'b0;
    wr_take  = 1'b0;
    unique case (state)
      ST_START:  cmd_e = CMD_START;
      ST_DEV:    begin cmd_e = CMD_WRITE; cmd_data = {dev, 1'b0}; end
      ST_OFS:    begin cmd_e = CMD_WRITE; cmd_data = ofs_byte; end
      ST_DATA:   begin cmd_e = CMD_WRITE; cmd_data = wr_data; wr_take = issue; end
      ST_RSTART: cmd_e = CMD_RSTART;
      ST_RDEV:   begin cmd_e = CMD_WRITE; cmd_data = {dev, 1'b1}; end
      ST_READ:   begin cmd_e = CMD_READ; cmd_last = last; end
      default:   cmd_e = CMD_STOP;
    endcase
  end
  assign cmd_valid = issue;
  assign cmd       = cmd_e;

  // next-state logic
  always_comb begin
    state_d = state;   pend_d = pend;     abort_d = abort;
    rd_d    = rd_mode; dev_d  = dev;      idx_d   = idx;
    done_d  = 1'b0;    err_d  = 1'b0;     cnt_d   = done_cnt;
    rdv_d   = 1'b0;    rdat_d = rd_data;  clr_d   = 1'b0;
    load    = 1'b0;    adv    = 1'b0;
    if (issue) pend_d = 1'b1;
    case (state)
      ST_IDLE: if (req_valid) begin
        if (arb_lost) begin
          clr_d = 1'b1; done_d = 1'b1; err_d = 1'b1; cnt_d = '0;
        end else if (req_len == '0) begin
          done_d = 1'b1; cnt_d = '0;
        end else begin
          load = 1'b1; rd_d = req_read; dev_d = req_dev;
          abort_d = 1'b0; state_d = ST_START;
        end
      end
      ST_WAIT: if (wait_fin) begin
        if (remain == '0) begin
          done_d = 1'b1; cnt_d = moved; state_d = ST_IDLE;
        end else state_d = ST_START;
      end
      default: if (fin) begin
        pend_d = 1'b0;
        if (!eng_ok && state != ST_STOP) begin
          abort_d = 1'b1; state_d = ST_STOP;
        end else if (!eng_ok) begin
          done_d = 1'b1; err_d = 1'b1; cnt_d = moved; state_d = ST_IDLE;
        end else begin
          case (state)
            ST_START: state_d = ST_DEV;
            ST_DEV: begin idx_d = 1'(OFS_BYTES - 1); state_d = ST_OFS; end
            ST_OFS:
              if (idx != '0)   idx_d = idx - 1'b1;
              else if (rd_mode) state_d = ST_RSTART;
              else              state_d = ST_DATA;
            ST_DATA: begin
              adv = 1'b1;
              if (last || page_end) state_d = ST_STOP;
            end
            ST_STOP:
              if (abort || rd_mode) begin
                done_d = 1'b1; err_d = abort; cnt_d = moved; state_d = ST_IDLE;
              end else state_d = ST_WAIT;
            ST_RSTART: state_d = ST_RDEV;
            ST_RDEV:   state_d = ST_READ;
            ST_READ: begin
              adv = 1'b1; rdv_d = 1'b1; rdat_d = eng_rdata;
              if (last) state_d = ST_STOP;
            end
            default: state_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; pend <= 1'b0; abort <= 1'b0; rd_mode <= 1'b0;
      dev <= '0; idx <= '0; done <= 1'b0; done_err <= 1'b0; done_cnt <= '0;
      rd_valid <= 1'b0; rd_data <= '0; arb_clr <= 1'b0;
    end else begin
      state <= state_d; pend <= pend_d; abort <= abort_d; rd_mode <= rd_d;
      dev <= dev_d; idx <= idx_d; done <= done_d; done_err <= err_d;
      done_cnt <= cnt_d; rd_valid <= rdv_d; rd_data <= rdat_d; arb_clr <= clr_d;
    end
  end
endmodule

// File: rtl/ee_page_seq_chk.sv
module ee_page_seq_chk #(
  parameter int WAIT_CYC = 330000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       arb_lost,
  input logic       arb_clr,
  input logic       done,
  input logic       done_err,
  input logic       rd_valid,
  input logic       cmd_valid,
  input logic [2:0] cmd,
  input logic       eng_done,
  input logic       eng_ok
);
  logic        outst, gap_arm;
  logic [2:0]  last_cmd;
  logic [31:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= 1'b0; last_cmd <= 3'd0; gap_arm <= 1'b0; gap <= '0;
    end else begin
      if (cmd_valid) begin outst <= 1'b1; last_cmd <= cmd; end
      else if (eng_done) outst <= 1'b0;
      if (!busy) gap_arm <= 1'b0;
      else if (eng_done && outst && last_cmd == 3'd2) begin gap_arm <= 1'b1; gap <= '0; end
      else if (cmd_valid && cmd == 3'd0) gap_arm <= 1'b0;
      else if (gap_arm && gap != 32'hFFFF_FFFF) gap <= gap + 1'b1;
    end
  end

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !cmd_valid);
  a_r8_arb_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && arb_lost) |=> (done && done_err && arb_clr));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_read_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
  a_r5_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 3'd0 && gap_arm) |-> (gap >= 32'(WAIT_CYC)));
  a_r9_stop_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (outst && eng_done && !eng_ok && last_cmd != 3'd2) |=> (cmd_valid && cmd == 3'd2));
endmodule

bind ee_page_seq ee_page_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .arb_lost(arb_lost), .arb_clr(arb_clr), .done(done), .done_err(done_err),
  .rd_valid(rd_valid), .cmd_valid(cmd_valid), .cmd(cmd),
  .eng_done(eng_done), .eng_ok(eng_ok));

// File: tb/tb_ee_page_seq.sv
module tb_ee_page_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WAITC = 20;
  localparam int DEV = 7'h50;

  logic clk, rst_n;
  logic req_valid, req_read, wr_take, rd_valid, busy, done, done_err;
  logic arb_lost, arb_clr, cmd_valid, cmd_last, eng_done, eng_ok;
  logic [6:0] req_dev;
  logic [15:0] req_ofs;
  logic [7:0] req_len, wr_data, rd_data, done_cnt, cmd_data, eng_rdata;
  logic [2:0] cmd;

  ee_page_seq #(.OFS_BYTES(2), .LEN_W(8), .PAGE(8), .WAIT_CYC(WAITC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_dev(req_dev), .req_ofs(req_ofs), .req_len(req_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .done(done), .done_cnt(done_cnt), .done_err(done_err), .arb_lost(arb_lost),
    .arb_clr(arb_clr), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .eng_done(eng_done), .eng_ok(eng_ok), .eng_rdata(eng_rdata));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int exp_q[$];
  int wr_idx, rd_seen, rd_issued, cmd_idx, fail_idx, lat, stop_cyc;
  bit stop_pend, gap_chk, got_done, clr_seen, cur_stop, cur_ok;
  int got_cnt, got_err;
  string cur_req;

  task automatic chk(input bit c, input string r, input string w, input int a, input int e);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, w, a, e);
    end
  endtask

  function automatic int enc(input int c, input int d, input int l);
    return c * 1024 + d * 2 + l;
  endfunction

  // responder and per-clock comparison against the expected command queue
  always @(negedge clk) begin
    cyc++;
    if (eng_done) eng_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        eng_done = 1'b1; eng_ok = cur_ok;
        if (cur_stop) begin stop_cyc = cyc; stop_pend = 1'b1; end
      end
    end
    if (cmd_valid) begin
      if (exp_q.size() == 0)
        chk(0, cur_req, "unexpected extra command", int'(cmd), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(enc(int'(cmd), int'(cmd_data), (cmd == 3'd4) ? int'(cmd_last) : 0) == e,
            cur_req, "command code/data/last", enc(int'(cmd), int'(cmd_data),
            (cmd == 3'd4) ? int'(cmd_last) : 0), e);
      end
      if (cmd == 3'd0 && stop_pend) begin
        chk(cyc - stop_cyc == WAITC + 1, "R5", "gap STOP->START", cyc - stop_cyc, WAITC + 1);
        stop_pend = 1'b0;
      end
      cur_stop = (cmd == 3'd2);
      cur_ok = (cmd_idx != fail_idx);
      if (cmd == 3'd4) begin eng_rdata = 8'h5A ^ 8'(rd_issued); rd_issued++; end
      cmd_idx++;
      lat = 2;
    end
    if (wr_take) begin wr_idx++; wr_data = 8'hC0 + 8'(wr_idx); end
    if (rd_valid) begin
      chk(rd_data == (8'h5A ^ 8'(rd_seen)), "R7", "read byte", int'(rd_data), int'(8'h5A ^ 8'(rd_seen)));
      rd_seen++;
    end
    if (arb_clr) begin arb_lost = 1'b0; clr_seen = 1'b1; end
    if (done) begin
      got_done = 1'b1; got_cnt = int'(done_cnt); got_err = int'(done_err);
      if (gap_chk && stop_pend)
        chk(cyc - stop_cyc == WAITC + 1, "R5", "gap STOP->done", cyc - stop_cyc, WAITC + 1);
      stop_pend = 1'b0;
    end
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic run(input bit rd, input int ofs, input int len, input int fidx,
                     input bit arb, input string rq);
    int full[$], isd[$], q[$];
    int o = ofs, rem = len, k = 0, ecnt = 0, eerr;
    if (rd) begin
      full = '{enc(0,0,0), enc(3,DEV*2,0), enc(3,(ofs>>8)&255,0), enc(3,ofs&255,0),
               enc(1,0,0), enc(3,DEV*2+1,0)};
      isd = '{0,0,0,0,0,0};
      for (int i = 0; i < len; i++) begin full.push_back(enc(4,0,i==len-1)); isd.push_back(1); end
      full.push_back(enc(2,0,0)); isd.push_back(0);
    end else begin
      while (rem > 0) begin
        full.push_back(enc(0,0,0)); full.push_back(enc(3,DEV*2,0));
        full.push_back(enc(3,(o>>8)&255,0)); full.push_back(enc(3,o&255,0));
        repeat (4) isd.push_back(0);
        do begin
          full.push_back(enc(3,(8'hC0 + k) & 255,0)); isd.push_back(1);
          k++; o = (o + 1) & 16'hFFFF; rem--;
        end while (rem > 0 && (o % 8) != 0);
        full.push_back(enc(2,0,0)); isd.push_back(0);
      end
    end
    if (arb) full = {};
    eerr = arb || (fidx >= 0 && fidx < full.size());
    for (int i = 0; i < full.size(); i++) begin
      if (eerr && !arb && i > fidx) break;
      q.push_back(full[i]);
      if (isd[i] != 0 && !(eerr && i == fidx)) ecnt++;
    end
    if (eerr && !arb && (full[fidx] / 1024) != 2) q.push_back(enc(2,0,0));
    if (arb) ecnt = 0;
    @(negedge clk);
    exp_q = q; cur_req = rq;
    wr_idx = 0; wr_data = 8'hC0; rd_seen = 0; rd_issued = 0; cmd_idx = 0;
    fail_idx = fidx; got_done = 0; stop_pend = 0; clr_seen = 0;
    gap_chk = !rd && !eerr; arb_lost = arb;
    req_read = rd; req_dev = 7'(DEV); req_ofs = 16'(ofs); req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000 && !got_done; i++) @(negedge clk);
    chk(got_done, rq, "done seen", int'(got_done), 1);
    chk(got_cnt == ecnt, rq, "done_cnt", got_cnt, ecnt);
    chk(got_err == eerr, rq, "done_err", got_err, eerr);
    chk(exp_q.size() == 0, rq, "commands left unissued", exp_q.size(), 0);
    if (rd && !eerr) chk(rd_seen == len, "R7", "read bytes delivered", rd_seen, len);
    if (arb) chk(clr_seen, "R8", "arb_clr pulse", int'(clr_seen), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_read = 0; req_dev = '0; req_ofs = '0; req_len = '0;
    wr_data = 8'hC0; arb_lost = 0; eng_done = 0; eng_ok = 0; eng_rdata = '0;
    lat = 0; fail_idx = -1; stop_pend = 0; gap_chk = 0; cur_req = "R10";
    repeat (3) @(negedge clk);
    chk(!done && !cmd_valid && !busy, "R10", "reset outputs quiet",
        int'({done, cmd_valid, busy}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 16'h0010, 8, -1, 0, "R1 R2 R3 aligned page write");
    run(0, 16'h0005, 13, -1, 0, "R4 R5 unaligned write split 3+8+2");
    run(0, 16'h01FE, 3, -1, 0, "R2 R3 write across high-byte carry");
    run(1, 16'h0123, 4, -1, 0, "R6 R7 block read");
    run(1, 16'h00FF, 1, -1, 0, "R6 single-byte read");
    run(0, 16'h0040, 0, -1, 0, "R10 zero-length request");
    run(0, 16'h0040, 4, -1, 1, "R8 arbitration lost");
    run(0, 16'h0000, 4, 1, 0, "R9 device address not acknowledged");
    run(0, 16'h0006, 6, 12, 0, "R9 data byte failure in second page");
    run(1, 16'h0020, 3, 3, 0, "R9 read offset low byte failure");
    run(0, 16'h0030, 17, -1, 0, "R3 R5 three full-page-order bursts");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule